// File: doc/BRIEF.md
# Two-Port Inter-Processor Message Mailbox

This block passes 32-bit words between two processors, called side A and side B, that share one clock. Each side sees the same small register window. Four addresses are message slots. A write to slot n sends a word to the other side, and a read of slot n picks up the word the other side sent. The window also holds a status word and a control word. Every slot has one occupancy flag per direction. Hardware raises the flag when a word is posted and drops it when the word is collected. The sender sees the flag as "transmit slot empty" and the receiver sees it as "receive slot full".

Each side has a level interrupt. It is raised when any status condition is set and its enable bit in that side's control word is also set. A hardware-only "event pending" bit tells a side that at least one received word is waiting. In every 4-bit per-channel field, the bit order is reversed: channel 0 sits at the top bit of the field. Raising general-purpose interrupts towards the partner is not handled by this block, so their pending field always reads zero. Their enable bits are still stored.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset, on both sides every transmit-empty flag is 1, every receive-full flag is 0, the control word is 0 and the interrupt output is 0.
- R2: A word written to message address n (0..3) on one side is returned by a read of address n on the other side.
- R3: A write to message address n clears the writer's transmit-empty flag n and sets the partner's receive-full flag n.
- R4: A read of message address n clears the reader's receive-full flag n and sets the partner's transmit-empty flag n.
- R5: A write to the status address (4) changes no flag.
- R6: The status word (address 4) has transmit-empty in bits [3:0], receive-full in [7:4], general-interrupt pending in [11:8] (always 0) and event pending in bit 12. The control word (address 5) has transmit-empty enables in [3:0], receive-full enables in [7:4] and general-interrupt enables in [11:8]. Within each 4-bit field, channel n is at field bit 3-n.
- R7: Event pending (status bit 12) equals the OR of that side's receive-full flags, whatever software writes.
- R8: The interrupt output is the registered OR of (status bits [11:0] AND control bits [11:0]). It follows a flag or control change one clock later.
- R9: A write to a slot that is already full replaces the held word. The flags stay as they are and no error is raised.
- R10: When the sender writes slot n in the same cycle that the receiver reads slot n, the read returns the old word, and the flag stays full, holding the new word.
- R11: Read data is registered and appears the cycle after the read strobe. The control word reads back as written, in bits [11:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst | input | 1 | Synchronous active-high reset |
| a_wr_en | input | 1 | Side A write strobe |
| a_rd_en | input | 1 | Side A read strobe |
| a_addr | input | 3 | Side A register address |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A read data, one cycle after the strobe |
| a_irq | output | 1 | Side A level interrupt |
| b_wr_en | input | 1 | Side B write strobe |
| b_rd_en | input | 1 | Side B read strobe |
| b_addr | input | 3 | Side B register address |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B read data, one cycle after the strobe |
| b_irq | output | 1 | Side B level interrupt |

## Verification
The bench builds the block with its defaults: four channels, 32-bit words and a 3-bit address. With these values every bit of the reversed status and control fields can be reached and checked. Traffic runs in both directions. The bench covers overwrite of a full slot, a write and a read of the same slot in the same cycle, and interrupts driven both by receive-full enables and by transmit-empty enables.

// File: rtl/ipc_mailbox_pkg.sv
package ipc_mailbox_pkg;

  typedef enum logic [1:0] {
    SEL_MSG  = 2'd0,
    SEL_STAT = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  function automatic int unsigned stat_width(input int unsigned nch);
    return 3 * nch + 1;
  endfunction

  function automatic int unsigned ctrl_width(input int unsigned nch);
    return 3 * nch;
  endfunction

endpackage

// File: rtl/mbx_channel.sv
module mbx_channel #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_en,
  output logic [DATA_W-1:0] data_o,
  output logic              full_o
);
  logic [DATA_W-1:0] word_q;
  logic              full_q;

  always_ff @(posedge clk) begin
    if (wr_en) word_q <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)        full_q <= 1'b0;
    else if (wr_en) full_q <= 1'b1;
    else if (rd_en) full_q <= 1'b0;
  end

  assign data_o = word_q;
  assign full_o = full_q;
endmodule

// File: rtl/mbx_side.sv
module mbx_side
  import ipc_mailbox_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3,
  localparam int STAT_W = stat_width(NUM_CH),
  localparam int CTRL_W = ctrl_width(NUM_CH)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic                     rd_en,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        wdata,
  output logic [DATA_W-1:0]        rdata,
  output logic                     irq,
  output logic [NUM_CH-1:0]        tx_wr,
  output logic [NUM_CH-1:0]        rx_rd,
  input  logic [NUM_CH-1:0]        tx_full_in,
  input  logic [NUM_CH-1:0]        rx_full_in,
  input  logic [NUM_CH*DATA_W-1:0] rx_data_in,
  output logic [CTRL_W-1:0]        ctrl_o
);
  reg_sel_e          sel;
  logic [CTRL_W-1:0] ctrl_q;
  logic [STAT_W-1:0] stat;
  logic [DATA_W-1:0] rdata_q, rd_mux, msg_mux;
  logic              irq_q;

  always_comb begin
    if (addr < ADDR_W'(NUM_CH))             sel = SEL_MSG;
    else if (addr == ADDR_W'(NUM_CH))       sel = SEL_STAT;
    else if (addr == ADDR_W'(NUM_CH + 1))   sel = SEL_CTRL;
    else                                    sel = SEL_NONE;
  end

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    assign tx_wr[n] = wr_en && (sel == SEL_MSG) && (addr == ADDR_W'(n));
    assign rx_rd[n] = rd_en && (sel == SEL_MSG) && (addr == ADDR_W'(n));
    assign stat[NUM_CH-1-n]          = ~tx_full_in[n];
    assign stat[2*NUM_CH-1-n]        = rx_full_in[n];
    assign stat[3*NUM_CH-1-n]        = 1'b0;
  end
  assign stat[3*NUM_CH] = |rx_full_in;

  always_comb begin
    msg_mux = '0;
    for (int n = 0; n < NUM_CH; n++) begin
      if (addr == ADDR_W'(n)) msg_mux = rx_data_in[n*DATA_W +: DATA_W];
    end
  end

  always_comb begin
    unique case (sel)
      SEL_MSG:  rd_mux = msg_mux;
      SEL_STAT: rd_mux = DATA_W'(stat);
      SEL_CTRL: rd_mux = DATA_W'(ctrl_q);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (wr_en && sel == SEL_CTRL) ctrl_q <= wdata[CTRL_W-1:0];
      if (rd_en) rdata_q <= rd_mux;
      irq_q <= |(stat[CTRL_W-1:0] & ctrl_q);
    end
  end

  assign rdata  = rdata_q;
  assign irq    = irq_q;
  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
  import ipc_mailbox_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 32,
  localparam int ADDR_W = $clog2(NUM_CH + 2),
  localparam int CTRL_W = ctrl_width(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              a_wr_en,
  input  logic              a_rd_en,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  output logic              a_irq,
  input  logic              b_wr_en,
  input  logic              b_rd_en,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata,
  output logic              b_irq
);
  logic [NUM_CH-1:0]        a_tx_wr, a_rx_rd, b_tx_wr, b_rx_rd;
  logic [NUM_CH-1:0]        full_ab, full_ba;
  logic [NUM_CH*DATA_W-1:0] data_ab, data_ba;
  logic [CTRL_W-1:0]        a_ctrl, b_ctrl;

  for (genvar n = 0; n < NUM_CH; n++) begin : g_lane
    mbx_channel #(.DATA_W(DATA_W)) u_ab (
      .clk(clk), .rst(rst), .wr_en(a_tx_wr[n]), .wdata(a_wdata),
      .rd_en(b_rx_rd[n]), .data_o(data_ab[n*DATA_W +: DATA_W]), .full_o(full_ab[n]));
    mbx_channel #(.DATA_W(DATA_W)) u_ba (
      .clk(clk), .rst(rst), .wr_en(b_tx_wr[n]), .wdata(b_wdata),
      .rd_en(a_rx_rd[n]), .data_o(data_ba[n*DATA_W +: DATA_W]), .full_o(full_ba[n]));
  end

  mbx_side #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_side_a (
    .clk(clk), .rst(rst), .wr_en(a_wr_en), .rd_en(a_rd_en), .addr(a_addr),
    .wdata(a_wdata), .rdata(a_rdata), .irq(a_irq), .tx_wr(a_tx_wr), .rx_rd(a_rx_rd),
    .tx_full_in(full_ab), .rx_full_in(full_ba), .rx_data_in(data_ba), .ctrl_o(a_ctrl));

  mbx_side #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_side_b (
    .clk(clk), .rst(rst), .wr_en(b_wr_en), .rd_en(b_rd_en), .addr(b_addr),
    .wdata(b_wdata), .rdata(b_rdata), .irq(b_irq), .tx_wr(b_tx_wr), .rx_rd(b_rx_rd),
    .tx_full_in(full_ba), .rx_full_in(full_ab), .rx_data_in(data_ab), .ctrl_o(b_ctrl));
endmodule

// File: rtl/ipc_mailbox_chk.sv
module ipc_mailbox_chk #(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 3,
  parameter int CTRL_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              a_wr_en,
  input logic              a_rd_en,
  input logic [ADDR_W-1:0] a_addr,
  input logic              b_wr_en,
  input logic              b_rd_en,
  input logic [ADDR_W-1:0] b_addr,
  input logic [NUM_CH-1:0] full_ab,
  input logic [NUM_CH-1:0] full_ba,
  input logic [CTRL_W-1:0] a_ctrl,
  input logic [CTRL_W-1:0] b_ctrl,
  input logic              a_irq,
  input logic              b_irq
);
  a_r1_flags_clear_after_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (full_ab == '0 && full_ba == '0 && !a_irq && !b_irq));

  for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
    a_r3_write_sets_full: assert property (@(posedge clk) disable iff (rst)
      (a_wr_en && a_addr == ADDR_W'(n)) |=> full_ab[n]);
    a_r4_read_clears_full: assert property (@(posedge clk) disable iff (rst)
      (b_rd_en && b_addr == ADDR_W'(n) && !(a_wr_en && a_addr == ADDR_W'(n))) |=> !full_ab[n]);
    a_r5_flag_holds: assert property (@(posedge clk) disable iff (rst)
      (!(b_wr_en && b_addr == ADDR_W'(n)) && !(a_rd_en && a_addr == ADDR_W'(n)))
        |=> $stable(full_ba[n]));
  end

  a_r8_irq_masked_a: assert property (@(posedge clk) disable iff (rst)
    (a_ctrl == '0) |=> !a_irq);
  a_r8_irq_masked_b: assert property (@(posedge clk) disable iff (rst)
    (b_ctrl == '0) |=> !b_irq);
endmodule

bind ipc_mailbox ipc_mailbox_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .CTRL_W(CTRL_W)) u_chk (
  .clk(clk), .rst(rst), .a_wr_en(a_wr_en), .a_rd_en(a_rd_en), .a_addr(a_addr),
  .b_wr_en(b_wr_en), .b_rd_en(b_rd_en), .b_addr(b_addr), .full_ab(full_ab),
  .full_ba(full_ba), .a_ctrl(a_ctrl), .b_ctrl(b_ctrl), .a_irq(a_irq), .b_irq(b_irq));

// File: tb/ipc_mailbox_tb_top.sv
module ipc_mailbox_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic a_wr_en = 0, a_rd_en = 0, b_wr_en = 0, b_rd_en = 0;
  logic [2:0] a_addr = '0, b_addr = '0;
  logic [31:0] a_wdata = '0, b_wdata = '0;
  logic [31:0] a_rdata, b_rdata;
  logic a_irq, b_irq;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [31:0] qa_exp[$], qb_exp[$];
  string qa_tag[$], qb_tag[$];
  logic rv_a = 0, rv_b = 0;
  bit m_ab[4], m_ba[4];

  always #2.5 clk = ~clk;

  ipc_mailbox dut_i (
    .clk(clk), .rst(rst),
    .a_wr_en(a_wr_en), .a_rd_en(a_rd_en), .a_addr(a_addr), .a_wdata(a_wdata),
    .a_rdata(a_rdata), .a_irq(a_irq),
    .b_wr_en(b_wr_en), .b_rd_en(b_rd_en), .b_addr(b_addr), .b_wdata(b_wdata),
    .b_rdata(b_rdata), .b_irq(b_irq));

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R6: channel n placed at bit 3-n of each field
  function automatic logic [31:0] exp_stat(input bit tx_busy[4], input bit rx_full[4]);
    logic [31:0] s = '0;
    for (int i = 0; i < 4; i++) begin
      s[3 - i] = ~tx_busy[i];
      s[7 - i] = rx_full[i];
      if (rx_full[i]) s[12] = 1'b1;
    end
    return s;
  endfunction

  // scoreboard monitor
  always @(posedge clk) begin
    rv_a <= a_rd_en;
    rv_b <= b_rd_en;
  end
  always @(negedge clk) begin
    if (rv_a && qa_exp.size() > 0) check(a_rdata, qa_exp.pop_front(), qa_tag.pop_front());
    if (rv_b && qb_exp.size() > 0) check(b_rdata, qb_exp.pop_front(), qb_tag.pop_front());
  end

  task automatic wr(input bit side_b, input logic [2:0] addr, input logic [31:0] d);
    @(negedge clk);
    if (side_b) begin b_wr_en = 1; b_addr = addr; b_wdata = d; if (addr < 4) m_ba[addr] = 1; end
    else        begin a_wr_en = 1; a_addr = addr; a_wdata = d; if (addr < 4) m_ab[addr] = 1; end
    @(negedge clk);
    a_wr_en = 0; b_wr_en = 0;
  endtask

  task automatic rd(input bit side_b, input logic [2:0] addr, input logic [31:0] exp, input string tag);
    @(negedge clk);
    if (side_b) begin
      b_rd_en = 1; b_addr = addr; qb_exp.push_back(exp); qb_tag.push_back(tag);
      if (addr < 4) m_ab[addr] = 0;
    end else begin
      a_rd_en = 1; a_addr = addr; qa_exp.push_back(exp); qa_tag.push_back(tag);
      if (addr < 4) m_ba[addr] = 0;
    end
    @(negedge clk);
    a_rd_en = 0; b_rd_en = 0;
  endtask

  task automatic rd_stat(input bit side_b, input string tag);
    if (side_b) rd(1, 3'd4, exp_stat(m_ba, m_ab), tag);
    else        rd(0, 3'd4, exp_stat(m_ab, m_ba), tag);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    idle(1);
    // R1 reset state
    check(32'(a_irq), 0, "R1 a_irq");
    check(32'(b_irq), 0, "R1 b_irq");
    rd(0, 3'd4, 32'h0000_000F, "R1 status A");
    rd(1, 3'd4, 32'h0000_000F, "R1 status B");
    rd(0, 3'd5, 32'h0, "R1 ctrl A");
    // R3 / R6 / R7
    wr(0, 3'd0, 32'h1111_1111);
    rd(0, 3'd4, 32'h0000_0007, "R3 R6 status A after tx0");
    rd(1, 3'd4, 32'h0000_108F, "R3 R7 status B after tx0");
    // R2 / R4
    rd(1, 3'd0, 32'h1111_1111, "R2 B gets A word");
    rd_stat(1, "R4 status B after read");
    rd(0, 3'd4, 32'h0000_000F, "R4 status A empty again");
    // reverse direction, ch3
    wr(1, 3'd3, 32'hDEAD_BEEF);
    rd(0, 3'd4, 32'h0000_101F, "R6 status A rx3 bit4");
    rd(1, 3'd4, 32'h0000_000E, "R6 status B tx3 bit0");
    // R5 status write ignored
    wr(0, 3'd4, 32'hFFFF_FFFF);
    rd(0, 3'd4, 32'h0000_101F, "R5 status A unchanged");
    wr(0, 3'd4, 32'h0);
    rd(0, 3'd4, 32'h0000_101F, "R5 R7 ep survives write");
    // R9 overwrite
    wr(1, 3'd3, 32'hCAFE_F00D);
    rd(1, 3'd4, 32'h0000_000E, "R9 flags unchanged on overwrite");
    rd(0, 3'd3, 32'hCAFE_F00D, "R9 overwritten word");
    rd(1, 3'd4, 32'h0000_000F, "R4 status B after A read");
    // R8 / R11 rx-full interrupt, ch1 -> bit 6
    wr(0, 3'd5, 32'h0000_0040);
    rd(0, 3'd5, 32'h0000_0040, "R11 ctrl A readback");
    idle(1);
    check(32'(a_irq), 0, "R8 a_irq idle");
    wr(1, 3'd1, 32'h0BAD_0001);
    idle(1);
    check(32'(a_irq), 1, "R8 a_irq on rx1 full");
    rd(0, 3'd1, 32'h0BAD_0001, "R2 A gets B ch1");
    idle(1);
    check(32'(a_irq), 0, "R8 a_irq cleared");
    // R8 tx-empty interrupt, ch2 -> bit 1
    wr(1, 3'd5, 32'h0000_0002);
    idle(1);
    check(32'(b_irq), 1, "R8 b_irq tx2 empty");
    wr(1, 3'd2, 32'h2222_2222);
    idle(1);
    check(32'(b_irq), 0, "R8 b_irq tx2 busy");
    rd(0, 3'd2, 32'h2222_2222, "R2 A gets ch2");
    idle(1);
    check(32'(b_irq), 1, "R8 b_irq tx2 empty again");
    // R11 GI enables stored, GI pending zero
    wr(0, 3'd5, 32'hFFFF_FF00);
    rd(0, 3'd5, 32'h0000_0F00, "R11 ctrl A GI enables");
    idle(1);
    check(32'(a_irq), 0, "R6 GI pending always zero");
    // R10 simultaneous write and read
    wr(0, 3'd0, 32'hAAAA_0001);
    @(negedge clk);
    a_wr_en = 1; a_addr = 3'd0; a_wdata = 32'hAAAA_0002;
    b_rd_en = 1; b_addr = 3'd0;
    qb_exp.push_back(32'hAAAA_0001); qb_tag.push_back("R10 read returns old word");
    @(negedge clk);
    a_wr_en = 0; b_rd_en = 0;
    rd(1, 3'd4, 32'h0000_108F, "R10 flag stays full");
    rd(1, 3'd0, 32'hAAAA_0002, "R10 new word held");
    rd(0, 3'd4, 32'h0000_000F, "R4 status A final");
    idle(3);
    check(qa_exp.size() + qb_exp.size(), 0, "R11 all reads returned");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule